// File: doc/BRIEF.md
# Shared Multiplier Functional Unit with Call Arbitration

This block is one multiplier shared by several independent callers. Each caller has its own port: a one-cycle call pulse, two operand buses that only need to be valid while that pulse is high, and a one-cycle completion pulse. All callers read the product from one shared result bus. When call pulses collide, or a call arrives while the unit is busy, a fixed-priority arbiter picks one call and holds the others pending. Each pending call keeps the operands it captured when its pulse arrived.

A call-control stage records which port was granted and loads that port's operands into the body's argument registers. When the body reports that it has finished, the call-control stage returns a completion pulse on the recorded port only. The body is a shift-and-add multiplier written as a loop. On each step the updated operands pass back through the argument multiplexer into the same registers. The loop stops as soon as either operand reaches zero.

Top module: `shared_mul_unit`

## Requirements
- R1: While the synchronous active-high reset is applied, and in the first cycle after it is released, every completion pulse is low and the result bus is zero.
- R2: A call with operands a and b returns (a*b) mod 2^16 on the shared result bus. The result is valid in the cycle when the completion pulse is high.
- R3: Completion is a single-cycle pulse, and it appears only on the port whose call it finishes. At most one completion bit is high in any cycle.
- R4: If either operand is zero, the completion pulse is high two cycles after the cycle of the call pulse, and the result is zero.
- R5: If the second operand is 1 and the first operand is nonzero, the completion pulse is high three cycles after the call pulse, and the result equals the first operand.
- R6: Port priority is fixed: bit 0 beats bit 1, and bit 1 beats bit 2. When several call pulses arrive in the same cycle, the calls are served in that order.
- R7: A call pulse that loses arbitration, or that arrives while a call is in progress, is not lost. It is served later, using the operand values present during its own pulse, even if those buses change afterwards.
- R8: The result bus changes only in a cycle in which a completion pulse is high. Between completions it holds the last product, both while the unit is idle and while a new call is being computed.
- R9: Applying reset during a call drops that call and all pending calls. No completion pulse follows, and the result bus reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | NCALL (3) | One call pulse per port |
| arg_x_i | input | NCALL*W (48) | First operand per port; port p uses bits [p*W +: W] |
| arg_y_i | input | NCALL*W (48) | Second operand per port; port p uses bits [p*W +: W] |
| done_o | output | NCALL (3) | One completion pulse per port |
| result_o | output | W (16) | Shared product output |

## Verification
The assertions assume that a caller does not pulse its port again before its previous call has completed. Under that assumption each port has at most one outstanding call, so completions can never fall in consecutive cycles. The directed tests follow this rule: every port waits for its own completion before it calls again. Operands are changed only after the pulse cycle, to show that the captured values are the ones used. Reset is applied mid-call only from the bench's reset scenario.

// File: rtl/shmul_pkg.sv
package shmul_pkg;
    parameter int unsigned CALLERS_DEF = 3;
    parameter int unsigned WIDTH_DEF   = 16;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_BUSY = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/shmul_arb.sv
module shmul_arb #(
    parameter int unsigned NCALL = shmul_pkg::CALLERS_DEF,
    parameter int unsigned W     = shmul_pkg::WIDTH_DEF,
    localparam int unsigned IW   = (NCALL > 1) ? $clog2(NCALL) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCALL-1:0]   call_i,
    input  logic [NCALL*W-1:0] x_i,
    input  logic [NCALL*W-1:0] y_i,
    input  logic               accept_i,
    output logic               grant_o,
    output logic [IW-1:0]      grant_idx_o,
    output logic [W-1:0]       gx_o,
    output logic [W-1:0]       gy_o
);
    typedef struct packed {
        logic [NCALL-1:0]        pend;
        logic [NCALL-1:0][W-1:0] hx;
        logic [NCALL-1:0][W-1:0] hy;
    } arb_t;

    arb_t q, d;
    logic [NCALL-1:0] req;
    logic [IW-1:0]    win;

    always_comb begin
        d   = q;
        req = q.pend | call_i;
        win = '0;
        for (int i = NCALL - 1; i >= 0; i--) begin
            if (req[i]) win = IW'(i);
        end
        grant_o     = accept_i && (req != '0);
        grant_idx_o = win;
        gx_o        = '0;
        gy_o        = '0;
        for (int i = 0; i < NCALL; i++) begin
            if (call_i[i]) begin
                d.hx[i] = x_i[i*W +: W];
                d.hy[i] = y_i[i*W +: W];
            end
            if (win == IW'(i)) begin
                gx_o = call_i[i] ? x_i[i*W +: W] : q.hx[i];
                gy_o = call_i[i] ? y_i[i*W +: W] : q.hy[i];
            end
        end
        d.pend = req;
        for (int i = 0; i < NCALL; i++) begin
            if (grant_o && win == IW'(i)) d.pend[i] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/shmul_ctrl.sv
module shmul_ctrl #(
    parameter int unsigned NCALL = shmul_pkg::CALLERS_DEF,
    localparam int unsigned IW   = (NCALL > 1) ? $clog2(NCALL) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_i,
    input  logic [IW-1:0]    grant_idx_i,
    input  logic             fin_i,
    output logic             accept_o,
    output logic             invoke_o,
    output logic [NCALL-1:0] done_o
);
    import shmul_pkg::*;

    typedef struct packed {
        ctl_state_e       st;
        logic [IW-1:0]    idx;
        logic [NCALL-1:0] done;
    } ctl_t;

    ctl_t q, d;

    always_comb begin
        d        = q;
        d.done   = '0;
        accept_o = (q.st == CTL_IDLE);
        invoke_o = accept_o && grant_i;
        if (invoke_o) begin
            d.st  = CTL_BUSY;
            d.idx = grant_idx_i;
        end else if (q.st == CTL_BUSY && fin_i) begin
            d.st = CTL_IDLE;
            for (int i = 0; i < NCALL; i++) begin
                if (q.idx == IW'(i)) d.done[i] = 1'b1;
            end
        end
        done_o = q.done;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{st: CTL_IDLE, idx: '0, done: '0};
        else     q <= d;
    end
endmodule

// File: rtl/shmul_body.sv
module shmul_body #(
    parameter int unsigned W = shmul_pkg::WIDTH_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic         fin_o,
    output logic [W-1:0] result_o
);
    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] acc;
        logic         run;
        logic [W-1:0] res;
    } body_t;

    body_t q, d;
    logic [W-1:0] step_x, step_y, step_acc;

    always_comb begin
        d        = q;
        fin_o    = q.run && (q.x == '0 || q.y == '0);
        step_x   = q.x << 1;
        step_y   = q.y >> 1;
        step_acc = q.y[0] ? (q.acc + q.x) : q.acc;
        // argument mux: a new call or the loop-back of the iteration
        if (load_i) begin
            d.x   = x_i;
            d.y   = y_i;
            d.acc = '0;
            d.run = 1'b1;
        end else if (q.run) begin
            if (fin_o) begin
                d.run = 1'b0;
                d.res = q.acc;
            end else begin
                d.x   = step_x;
                d.y   = step_y;
                d.acc = step_acc;
            end
        end
        result_o = q.res;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/shared_mul_unit.sv
module shared_mul_unit #(
    parameter int unsigned NCALL = shmul_pkg::CALLERS_DEF,
    parameter int unsigned W     = shmul_pkg::WIDTH_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NCALL-1:0]   call_i,
    input  logic [NCALL*W-1:0] arg_x_i,
    input  logic [NCALL*W-1:0] arg_y_i,
    output logic [NCALL-1:0]   done_o,
    output logic [W-1:0]       result_o
);
    localparam int unsigned IW = (NCALL > 1) ? $clog2(NCALL) : 1;

    logic          accept, grant, invoke, fin;
    logic [IW-1:0] grant_idx;
    logic [W-1:0]  gx, gy;

    shmul_arb #(.NCALL(NCALL), .W(W)) u_arb (
        .clk(clk), .rst(rst), .call_i(call_i), .x_i(arg_x_i), .y_i(arg_y_i),
        .accept_i(accept), .grant_o(grant), .grant_idx_o(grant_idx),
        .gx_o(gx), .gy_o(gy)
    );

    shmul_ctrl #(.NCALL(NCALL)) u_ctrl (
        .clk(clk), .rst(rst), .grant_i(grant), .grant_idx_i(grant_idx),
        .fin_i(fin), .accept_o(accept), .invoke_o(invoke), .done_o(done_o)
    );

    shmul_body #(.W(W)) u_body (
        .clk(clk), .rst(rst), .load_i(invoke), .x_i(gx), .y_i(gy),
        .fin_o(fin), .result_o(result_o)
    );
endmodule

// File: rtl/shmul_checker.sv
module shmul_checker #(
    parameter int unsigned NCALL = shmul_pkg::CALLERS_DEF,
    parameter int unsigned W     = shmul_pkg::WIDTH_DEF
) (
    input logic             clk,
    input logic             rst,
    input logic [NCALL-1:0] done_o,
    input logic [W-1:0]     result_o
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (done_o == '0 && result_o == '0));

    assert_done_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_o));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        (done_o != '0) |=> (done_o == '0));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (done_o == '0 && !$past(rst)) |-> $stable(result_o));
endmodule

bind shared_mul_unit shmul_checker #(.NCALL(NCALL), .W(W)) u_chk (
    .clk(clk), .rst(rst), .done_o(done_o), .result_o(result_o)
);

// File: tb/shared_mul_unit_test.sv
module shared_mul_unit_test;
    localparam int NC = 3;
    localparam int W  = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NC-1:0]   call_i = '0;
    logic [NC*W-1:0] arg_x_i = '0;
    logic [NC*W-1:0] arg_y_i = '0;
    logic [NC-1:0]   done_o;
    logic [W-1:0]    result_o;

    int n_chk = 0;
    int n_bad = 0;

    shared_mul_unit #(.NCALL(NC), .W(W)) uut (
        .clk(clk), .rst(rst), .call_i(call_i), .arg_x_i(arg_x_i),
        .arg_y_i(arg_y_i), .done_o(done_o), .result_o(result_o)
    );

    always #10 clk = ~clk;

    function automatic logic [W-1:0] prod(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [31:0] p;
        p = a * b;
        return p[W-1:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_args(input int p, input logic [W-1:0] a, input logic [W-1:0] b);
        arg_x_i[p*W +: W] = a;
        arg_y_i[p*W +: W] = b;
    endtask

    // drive pulse mask for one cycle, then scramble the operand buses
    task automatic fire(input logic [NC-1:0] mask);
        call_i = mask;
        @(negedge clk);
        call_i  = '0;
        arg_x_i = {NC{16'hA5C3}};
        arg_y_i = {NC{16'h3C5A}};
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        while (done_o == '0 && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic t_reset;
        check("R1 done after reset", 32'(done_o), 0);
        check("R1 result after reset", 32'(result_o), 0);
    endtask

    task automatic t_basic;
        int c;
        set_args(1, 16'd3, 16'd5);
        fire(3'b010);
        wait_done(c);
        check("R2 product 3*5", 32'(result_o), 15);
        check("R3 done on port1 only", 32'(done_o), 32'b010);
        @(negedge clk);
        check("R3 done single cycle", 32'(done_o), 0);
    endtask

    task automatic t_zero;
        int c;
        set_args(2, 16'd1234, 16'd0);
        fire(3'b100);
        wait_done(c);
        check("R4 latency y=0", 32'(c), 1);
        check("R4 result y=0", 32'(result_o), 0);
        check("R4 done port2", 32'(done_o), 32'b100);
        @(negedge clk);
        set_args(0, 16'd0, 16'd77);
        fire(3'b001);
        wait_done(c);
        check("R4 latency x=0", 32'(c), 1);
        check("R4 result x=0", 32'(result_o), 0);
    endtask

    task automatic t_one;
        int c;
        @(negedge clk);
        set_args(0, 16'hBEEF, 16'd1);
        fire(3'b001);
        wait_done(c);
        check("R5 latency y=1", 32'(c), 2);
        check("R5 result y=1", 32'(result_o), 32'hBEEF);
    endtask

    task automatic t_wrap;
        int c;
        @(negedge clk);
        set_args(1, 16'h1234, 16'h5678);
        fire(3'b010);
        wait_done(c);
        check("R2 wrapped product", 32'(result_o), 32'(prod(16'h1234, 16'h5678)));
        @(negedge clk);
        set_args(2, 16'hFFFF, 16'hFFFF);
        fire(3'b100);
        wait_done(c);
        check("R2 all-ones product", 32'(result_o), 32'(prod(16'hFFFF, 16'hFFFF)));
    endtask

    task automatic t_prio;
        int c;
        logic [W-1:0] xs[NC];
        logic [W-1:0] ys[NC];
        @(negedge clk);
        xs = '{16'd7, 16'd300, 16'd41};
        ys = '{16'd9, 16'd11, 16'd1000};
        for (int p = 0; p < NC; p++) set_args(p, xs[p], ys[p]);
        fire(3'b111);
        for (int p = 0; p < NC; p++) begin
            wait_done(c);
            check("R6 service order", 32'(done_o), 32'(1 << p));
            check("R7 pending result", 32'(result_o), 32'(prod(xs[p], ys[p])));
            @(negedge clk);
        end
    endtask

    task automatic t_late;
        int c;
        @(negedge clk);
        set_args(2, 16'd3, 16'h8000);
        fire(3'b100);
        repeat (3) @(negedge clk);
        set_args(0, 16'd250, 16'd6);
        fire(3'b001);
        wait_done(c);
        check("R7 busy call first done", 32'(done_o), 32'b100);
        check("R7 busy call result", 32'(result_o), 32'(prod(16'd3, 16'h8000)));
        @(negedge clk);
        wait_done(c);
        check("R7 late call done port0", 32'(done_o), 32'b001);
        check("R7 late call captured args", 32'(result_o), 1500);
    endtask

    task automatic t_hold;
        int c;
        logic [W-1:0] keep;
        @(negedge clk);
        keep = result_o;
        repeat (8) @(negedge clk);
        check("R8 idle hold", 32'(result_o), 32'(keep));
        set_args(1, 16'd5, 16'hF000);
        fire(3'b010);
        repeat (6) @(negedge clk);
        check("R8 hold while computing", 32'(result_o), 32'(keep));
        wait_done(c);
        check("R8 new result at done", 32'(result_o), 32'(prod(16'd5, 16'hF000)));
    endtask

    task automatic t_rst_mid;
        int seen;
        @(negedge clk);
        set_args(2, 16'd9, 16'hFFFF);
        fire(3'b100);
        set_args(1, 16'd2, 16'd2);
        fire(3'b010);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            if (done_o != '0) seen++;
            @(negedge clk);
        end
        check("R9 no done after reset", 32'(seen), 0);
        check("R9 result cleared", 32'(result_o), 0);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_zero();
        t_one();
        t_wrap();
        t_prio();
        t_late();
        t_hold();
        t_rst_mid();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule